// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It combines what each branch did before with what the most recent branches did. A 2-bit global register records the outcomes of the last two resolved branches. A table of 16 entries is indexed by low bits of the branch address, with no tag check. Each entry holds four 2-bit saturating counters, and the global register picks one of them. The chosen counter's upper bit is the prediction. Branches that behave differently depending on the path taken to reach them can therefore be predicted separately for each recent path.

Fetch presents a lookup address every cycle and reads a combinational taken/not-taken answer. When a branch resolves, the back end pulses a resolve strobe with the branch address and its real outcome. The block then trains the one counter that the history selected and shifts the outcome into the history. Resolve has no back-pressure: the block takes it on every cycle the strobe is high. The lookup port is a plain address with no handshake.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the global history is 00, so every lookup predicts not taken until training begins.
- R2: The table index is address bits [5:2] (16 entries). Addresses that agree in those bits share an entry, because there is no tag.
- R3: The history is 2 bits wide. On each resolve the outcome (1 = taken) enters bit 0 and the old bit 0 moves to bit 1, so value 01 means the older branch was not taken and the newer one was taken. Without a resolve the history holds its value.
- R4: Each entry holds four counters numbered 0 to 3. Both the lookup and the update use the counter whose number equals the current history value.
- R5: A resolve changes only the one selected counter. The other three counters in that entry and all other entries keep their values.
- R6: A taken outcome raises the selected counter by one and a not-taken outcome lowers it by one, saturating at 3 and at 0.
- R7: The prediction is taken exactly when the selected counter is 2 or 3. A counter at 3 therefore needs two not-taken updates before it predicts not taken.
- R8: When a lookup and a resolve happen in the same cycle, the lookup sees the state from before that cycle's update. The update selects its counter with the history from before the shift.
- R9: Resolves may arrive on consecutive cycles, and each one is applied in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_taken | output | 1 | Prediction for lk_pc: 1 = taken |
| rs_valid | input | 1 | Resolve strobe, accepted every cycle it is high |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch: 1 = taken |

## Verification
One branch is trained with repeated taken and then repeated not-taken outcomes. This exercises saturation at both ends and the two-miss hysteresis. An alternating outcome pattern shows that the history steers separate counters: a predictor without correlation would stay wrong on that pattern. Addresses that differ only above bit 5 show that entries are shared without a tag. Trained entries are then read under other histories to show that untouched counters stay put. Same-cycle lookup and resolve, and long runs of back-to-back random resolves, separate pre-update reads and history ordering from other timing choices.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_RESET = ctr_t'(1);
  localparam ctr_t CTR_MAX   = '1;
  localparam ctr_t CTR_MIN   = '0;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken && cur != CTR_MAX) nxt = cur + ctr_t'(1);
    else if (!taken && cur != CTR_MIN) nxt = cur - ctr_t'(1);
    return nxt;
  endfunction
endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], outcome};
  end
endmodule

// File: rtl/bp_counter_bank.sv
module bp_counter_bank
  import bp_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  localparam int ENTRIES = 1 << IDX_W,
  localparam int WAYS    = 1 << HIST_W,
  localparam int FLAT_W  = ENTRIES * WAYS * CTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [HIST_W-1:0] upd_sel,
  input  logic              upd_taken,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [HIST_W-1:0] rd_sel,
  output ctr_t              rd_ctr,
  output logic [FLAT_W-1:0] ctr_flat
);
  ctr_t ctr_q [ENTRIES][WAYS];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic hit;
      assign hit = upd_en && (upd_idx == IDX_W'(e)) && (upd_sel == HIST_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q[e][w] <= CTR_RESET;
        else if (hit) ctr_q[e][w] <= ctr_step(ctr_q[e][w], upd_taken);
      end
      assign ctr_flat[(e*WAYS + w)*CTR_W +: CTR_W] = ctr_q[e][w];
    end
  end

  assign rd_ctr = ctr_q[rd_idx][rd_sel];
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 4,
  parameter int HIST_W  = 2,
  localparam int FLAT_W = (1 << IDX_W) * (1 << HIST_W) * CTR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken
);
  logic [IDX_W-1:0]  lk_idx, rs_idx;
  logic [HIST_W-1:0] hist_q;
  logic [FLAT_W-1:0] ctr_flat;
  ctr_t              lk_ctr;

  assign lk_idx = lk_pc[ALIGN_W +: IDX_W];
  assign rs_idx = rs_pc[ALIGN_W +: IDX_W];

  bp_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(rs_valid), .outcome(rs_taken), .hist(hist_q)
  );

  bp_counter_bank #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .upd_en(rs_valid), .upd_idx(rs_idx), .upd_sel(hist_q), .upd_taken(rs_taken),
    .rd_idx(lk_idx), .rd_sel(hist_q), .rd_ctr(lk_ctr), .ctr_flat(ctr_flat)
  );

  assign lk_taken = lk_ctr[CTR_W-1];
endmodule

// File: rtl/bp_checker.sv
module bp_checker
  import bp_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  localparam int WAYS   = 1 << HIST_W,
  localparam int FLAT_W = (1 << IDX_W) * WAYS * CTR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rs_valid,
  input logic              rs_taken,
  input logic [IDX_W-1:0]  rs_idx,
  input logic [HIST_W-1:0] hist,
  input logic [FLAT_W-1:0] ctr_all
);
  logic [IDX_W-1:0]  idx_d;
  logic [HIST_W-1:0] hist_d;
  ctr_t sel_now, sel_then;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_d  <= '0;
      hist_d <= '0;
    end else begin
      idx_d  <= rs_idx;
      hist_d <= hist;
    end
  end

  assign sel_now  = ctr_all[(int'(rs_idx)*WAYS + int'(hist))*CTR_W +: CTR_W];
  assign sel_then = ctr_all[(int'(idx_d)*WAYS + int'(hist_d))*CTR_W +: CTR_W];

  p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(hist));
  p_hist_newest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> hist[0] == $past(rs_taken));
  p_hist_age_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]));
  p_table_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(ctr_all));
  p_one_counter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> $countones(ctr_all ^ $past(ctr_all)) <= CTR_W);
  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && sel_now != CTR_MAX) |=> sel_then == $past(sel_now) + ctr_t'(1));
  p_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken && sel_now != CTR_MIN) |=> sel_then == $past(sel_now) - ctr_t'(1));
  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && sel_now == CTR_MAX) |=> sel_then == CTR_MAX);
  p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken && sel_now == CTR_MIN) |=> sel_then == CTR_MIN);
endmodule

bind corr_bpred bp_checker #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rs_valid(rs_valid), .rs_taken(rs_taken),
  .rs_idx(rs_idx), .hist(hist_q), .ctr_all(ctr_flat)
);

// File: tb/sim_corr_bpred.sv
module sim_corr_bpred;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic        rs_valid = 0;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 0;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int m_ctr [16][4];
  int m_hist;

  always #5 clk = ~clk;

  corr_bpred u0 (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
                 .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));

  function automatic int idx_of(input logic [31:0] pc);
    return int'(pc[5:2]);
  endfunction

  function automatic bit m_pred(input logic [31:0] pc);
    return m_ctr[idx_of(pc)][m_hist] >= 2;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lk_taken=%0b expected %0b (pc=%h hist=%0d)", tag, act, exp, lk_pc, m_hist);
    end
  endtask

  // one cycle: drive at negedge, compare before the edge, then advance the model
  task automatic step(input logic [31:0] lpc, input bit v, input logic [31:0] rpc,
                      input bit t, input string tag);
    int i;
    @(negedge clk);
    lk_pc = lpc; rs_valid = v; rs_pc = rpc; rs_taken = t;
    #1 check(lk_taken, m_pred(lpc), tag);
    @(posedge clk);
    if (v) begin
      i = idx_of(rpc);
      if (t && m_ctr[i][m_hist] < 3) m_ctr[i][m_hist]++;
      else if (!t && m_ctr[i][m_hist] > 0) m_ctr[i][m_hist]--;
      m_hist = ((m_hist << 1) | int'(t)) & 3;
    end
  endtask

  task automatic look(input logic [31:0] lpc, input string tag);
    step(lpc, 0, '0, 0, tag);
  endtask

  task automatic res(input logic [31:0] rpc, input bit t, input string tag);
    step(rpc, 1, rpc, t, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 16; e++) for (int w = 0; w < 4; w++) m_ctr[e][w] = 1;
    m_hist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: untrained table predicts not taken everywhere
    for (int e = 0; e < 16; e++) begin
      @(negedge clk); lk_pc = 32'(e << 2);
      #1 check(lk_taken, 1'b0, "R1");
    end

    // R6/R7: drive one branch to the top, then back down (hysteresis)
    repeat (6) res(32'h40, 1, "R6");
    look(32'h40, "R7");
    res(32'h40, 0, "R7");
    res(32'h40, 0, "R7");
    repeat (6) res(32'h40, 0, "R6");
    look(32'h40, "R7");

    // R2: aliasing through bits above the index
    repeat (4) res(32'h0000_1008, 1, "R2");
    look(32'h0000_0008, "R2");
    look(32'hFFFF_F008, "R2");

    // R3/R4: alternating outcome learned through history-selected counters
    for (int k = 0; k < 16; k++) res(32'h80, k[0], "R4");
    for (int k = 0; k < 6; k++) res(32'h80, k[0], "R3");

    // R5: untouched entries and ways stay put
    for (int e = 0; e < 16; e++) look(32'(e << 2), "R5");
    res(32'h0c, 0, "R5");
    res(32'h0c, 1, "R5");
    for (int e = 0; e < 16; e++) look(32'(e << 2), "R5");

    // R8: lookup and resolve of the same branch in one cycle
    for (int k = 0; k < 8; k++) res(32'h24, 1, "R8");
    for (int k = 0; k < 4; k++) step(32'h24, 1, 32'h24, 0, "R8");

    // R9: back-to-back random resolves with unrelated lookups
    for (int k = 0; k < 400; k++)
      step(32'($urandom_range(0, 255)), 1'($urandom_range(0, 3) != 0),
           32'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), "R9");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule